// File: doc/BRIEF.md
# Four-Bank Word-Interleaved Refill Memory

This block stores words in four independent banks and serves cache-block refills of four consecutive words. The two lowest bits of a word address pick the bank and the remaining bits pick the row inside that bank, so the four words of one block sit in four different banks. A block read starts all four banks in the same cycle and their access times overlap. The words then stream out one per cycle in bank order. A refill therefore costs one address cycle, six access cycles and four transfer cycles, which is 11 cycles in total. The same refill done as four serial accesses to a single bank would cost 32 cycles. Single-word writes are also accepted, and each one occupies only the bank it targets.

Requests enter through a valid/ready port. A request is taken in any cycle where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must hold the request and its payload steady. `req_ready` is computed from the payload that is presented. A read needs all four banks idle. A write needs only its target bank idle. Each bank stays busy for the six access cycles after it takes a request. The response side has no back-pressure: the requester must accept each word in the cycle it is marked valid. The timing makes sure that two refills can never overlap on the response port.

Top module: `interleaved_refill_mem`

## Requirements
- R1: After reset, `req_ready` is high for any request and `rsp_valid` is low.
- R2: Bits [1:0] of a word address select the bank and bits [ADDR_W-1:2] select the row, so consecutive word addresses land in consecutive banks and never collide with one another.
- R3: A block read accepted in cycle N returns word k of the block (address base+k) with `rsp_valid` high in cycle N+7+k for k = 0..3. `rsp_last` is high only with word 3, and `rsp_valid` is low in every cycle that carries no word.
- R4: For a block read, bits [1:0] of `req_addr` are ignored, and the block whose base has those bits cleared is returned.
- R5: A write stores `req_wdata` at `req_addr`, and any later read returns the most recently written value of each word.
- R6: A bank that accepts a request is busy in cycles N+1 to N+6 and free again in N+7. A write is accepted exactly when its target bank is free, whatever the other banks are doing.
- R7: A block read is accepted only in a cycle where all four banks are free. As a result, a read that follows another read is accepted no earlier than seven cycles after it.
- R8: Writes produce no response: `rsp_valid` stays low for them.
- R9: A request that meets `req_ready` low is not taken. If it is held, it is accepted in the first cycle its banks are free, and its timing then counts from that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = single-word write, 0 = four-word block read |
| req_addr | input | ADDR_W (8) | Word address; block base for reads |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | A refill word is on `rsp_data` |
| rsp_data | output | DATA_W (32) | Refill word |
| rsp_last | output | 1 | Marks the fourth word of a refill |

## Verification
The bench's reference model counts cycles from each handshake. For every accepted request it records the last cycle in which each bank is busy (N+6). For a read it also books the four expected words for cycles N+7 to N+10. On every falling edge the model compares `req_ready` against the bank-free rule for the request currently presented. It also compares the response port against whatever word is booked for that exact cycle, and it requires silence in all other cycles. This way a word that arrives one cycle early or late, or a ready that rises one cycle too soon, is caught in the cycle it happens.

// File: rtl/imem_pkg.sv
package imem_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } imem_op_e;

  function automatic int unsigned ceil_log2(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/imem_issue.sv
module imem_issue
  import imem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 4,
  localparam int BANK_BITS = ceil_log2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [NUM_BANKS-1:0] bank_busy,
  output logic                 req_ready,
  output logic [NUM_BANKS-1:0] bank_start
);
  imem_op_e              op;
  logic [BANK_BITS-1:0]  tgt_bank;
  logic                  accept;

  assign op       = req_write ? OP_WRITE : OP_READ;
  assign tgt_bank = req_addr[BANK_BITS-1:0];

  always_comb begin
    if (op == OP_WRITE) req_ready = !bank_busy[tgt_bank];
    else                req_ready = (bank_busy == '0);
  end

  assign accept = req_valid && req_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_start
    assign bank_start[b] = accept &&
                           ((op == OP_READ) || (tgt_bank == BANK_BITS'(b)));
  end

  // R7: a block read may only launch into a fully idle bank set
  assert_read_all_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_ready) |=> ($countones(bank_busy) == NUM_BANKS));
endmodule

// File: rtl/imem_bank.sv
module imem_bank #(
  parameter int DATA_W     = 32,
  parameter int ROW_W      = 6,
  parameter int ACCESS_LAT = 6,
  localparam int DEPTH = 1 << ROW_W,
  localparam int TMR_W = $clog2(ACCESS_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              rd_finish,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [TMR_W-1:0]  timer;
  logic              is_rd;
  logic [ROW_W-1:0]  row_q;

  assign busy      = (timer != '0);
  assign rd_finish = is_rd && (timer == TMR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
      is_rd <= 1'b0;
      row_q <= '0;
    end else if (start) begin
      timer <= TMR_W'(ACCESS_LAT);
      is_rd <= !wr;
      row_q <= row;
    end else if (busy) begin
      timer <= timer - TMR_W'(1);
      if (timer == TMR_W'(1)) is_rd <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (start && wr) store[row] <= wdata;
    if (rd_finish) rdata <= store[row_q];
  end

  // R6: a bank is never started while busy, and is busy right after a start
  assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  assert_occupied_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R3: the read completes on the last access cycle and frees the bank
  assert_finish_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_finish |=> !busy);
endmodule

// File: rtl/imem_serializer.sv
module imem_serializer
  import imem_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 4,
  localparam int BANK_BITS = ceil_log2(NUM_BANKS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              launch,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_q,
  output logic                              rsp_valid,
  output logic [DATA_W-1:0]                 rsp_data,
  output logic                              rsp_last
);
  logic                 active;
  logic [BANK_BITS-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sel    <= '0;
    end else if (launch) begin
      active <= 1'b1;
      sel    <= '0;
    end else if (active) begin
      if (sel == BANK_BITS'(NUM_BANKS - 1)) active <= 1'b0;
      sel <= sel + BANK_BITS'(1);
    end
  end

  assign rsp_valid = active;
  assign rsp_data  = bank_q[sel];
  assign rsp_last  = active && (sel == BANK_BITS'(NUM_BANKS - 1));

  // R3: a refill streams without gaps and ends after its last word
  assert_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |=> rsp_valid);
  assert_end_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> !rsp_valid);
  // R7: a new refill never starts while one is streaming
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !rsp_valid);
endmodule

// File: rtl/interleaved_refill_mem.sv
module interleaved_refill_mem
  import imem_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int NUM_BANKS  = 4,
  parameter int ACCESS_LAT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last
);
  localparam int BANK_BITS = ceil_log2(NUM_BANKS);
  localparam int ROW_W     = ADDR_W - BANK_BITS;

  logic [NUM_BANKS-1:0]             bank_busy;
  logic [NUM_BANKS-1:0]             bank_start;
  logic [NUM_BANKS-1:0]             bank_finish;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q;
  logic [ROW_W-1:0]                 row;

  assign row = req_addr[ADDR_W-1:BANK_BITS];

  imem_issue #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .bank_busy  (bank_busy),
    .req_ready  (req_ready),
    .bank_start (bank_start)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    imem_bank #(
      .DATA_W     (DATA_W),
      .ROW_W      (ROW_W),
      .ACCESS_LAT (ACCESS_LAT)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (bank_start[b]),
      .wr        (req_write),
      .row       (row),
      .wdata     (req_wdata),
      .busy      (bank_busy[b]),
      .rd_finish (bank_finish[b]),
      .rdata     (bank_q[b])
    );
  end

  imem_serializer #(
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (bank_finish[0]),
    .bank_q    (bank_q),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last)
  );

  // R3: all banks of a block finish their access in the same cycle
  assert_banks_in_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_finish[0] |-> (bank_finish == '1));
endmodule

// File: tb/interleaved_refill_mem_bench.sv
module interleaved_refill_mem_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_last;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  string tag = "R1";

  logic [31:0] mm [256];
  int          busy_until [4];
  logic [31:0] exp_d [int];
  bit          exp_l [int];

  always #10 clk = ~clk;

  interleaved_refill_mem u_interleaved_refill_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %0h expected %0h", tag, what, cyc, act, expv);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // reference model, evaluated mid-cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic er;
      int   b;
      int   base;
      b = int'(req_addr[1:0]);
      if (req_write) er = (busy_until[b] < cyc);
      else begin
        er = 1'b1;
        for (int i = 0; i < 4; i++) if (busy_until[i] >= cyc) er = 1'b0;
      end
      chk(req_ready, er, req_write ? "R6 ready(write)" : "R7 ready(read)");
      if (req_valid && er) begin
        if (req_write) begin
          mm[req_addr] = req_wdata;
          busy_until[b] = cyc + 6;
        end else begin
          base = int'(req_addr) & ~3;
          for (int i = 0; i < 4; i++) busy_until[i] = cyc + 6;
          for (int k = 0; k < 4; k++) begin
            exp_d[cyc + 7 + k] = mm[base + k];
            exp_l[cyc + 7 + k] = (k == 3);
          end
        end
      end
      chk(rsp_valid, exp_d.exists(cyc), "R3 rsp_valid");
      if (exp_d.exists(cyc)) begin
        chk(rsp_data, exp_d[cyc], "R3 rsp_data");
        chk(rsp_last, exp_l[cyc], "R3 rsp_last");
        exp_d.delete(cyc);
        exp_l.delete(cyc);
      end
    end
  end

  task automatic issue(input bit wr, input int addr, input logic [31:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr[7:0];
    req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) busy_until[i] = -100;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready, 1'b1, "R1 ready after reset");
    chk(rsp_valid, 1'b0, "R1 rsp_valid after reset");
    @(posedge clk); #1;

    // R5/R2/R9: fill 16 consecutive words; the fifth write revisits bank 0 and stalls
    tag = "R2";
    for (int a = 0; a < 16; a++) issue(1'b1, a, 32'hA000_0000 + a);
    tag = "R8";
    idle(10);

    // R3/R7: two reads back to back; the second stalls until all banks free
    tag = "R3";
    issue(1'b0, 0, '0);
    tag = "R7";
    issue(1'b0, 4, '0);
    idle(14);

    // R4: misaligned read address returns the aligned block
    tag = "R4";
    issue(1'b0, 9, '0);
    idle(12);

    // R5/R6/R9: overwrite then read the block, read must wait for the bank
    tag = "R5";
    issue(1'b1, 5, 32'h5555_0005);
    issue(1'b1, 6, 32'h6666_0006);
    tag = "R9";
    issue(1'b0, 4, '0);
    issue(1'b1, 5, 32'h7777_0005);
    issue(1'b0, 6, '0);
    idle(12);

    // R2/R6: high rows, writes to distinct banks overlap
    tag = "R6";
    issue(1'b1, 8'hF3, 32'hDEAD_00F3);
    issue(1'b1, 8'hF0, 32'hDEAD_00F0);
    issue(1'b1, 8'hF2, 32'hDEAD_00F2);
    issue(1'b1, 8'hF1, 32'hDEAD_00F1);
    issue(1'b1, 8'h33, 32'hBEEF_0033);
    tag = "R2";
    issue(1'b0, 8'hF0, '0);
    issue(1'b0, 8'h30, '0);
    idle(14);

    tag = "R8";
    issue(1'b1, 8'h80, 32'h1234_5678);
    idle(10);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule